// File: doc/BRIEF.md
# Four-Input SIMD Super-Operation Unit

This functional unit reads four 64-bit argument vectors in one issue and returns up to two 64-bit result vectors. Work that would otherwise need between two and fifteen simple two-input operations is merged into one unit. A 3-bit operation code selects one of six media kernels:

- a per-lane select between two vectors
- a high or low 16-bit 4x4 transpose
- a rounded four-way pixel average
- a pair of signed 32x32 multiplies that keep the full 64-bit products
- a fixed-point 2-D rotation with rounding and saturation

Every operation passes through the same three-register pipeline. A valid flag travels alongside the data, so the unit takes a new operation on every cycle. In the 16-bit element layout used throughout, element 0 of a vector sits in bits [63:48] and element 3 sits in bits [15:0].

Top module: `simd_superop_unit`

## Requirements
- R1: An operation with `in_vld` high that is sampled at a rising edge raises `out_vld` after the third rising edge, counting that sampling edge as the first. The matching results appear at the same time. A cycle with `in_vld` low produces `out_vld` low three edges later.
- R2: While `rst_n` is low, `out_vld`, `out_r0` and `out_r1` are all zero.
- R3: Code 0 (select). For each 16-bit lane, `out_r0` takes the lane of `in_a1` when the same lane of `in_a2` is nonzero, and the lane of `in_a0` otherwise. `out_r1` is zero.
- R4: Code 1 (transpose high). The four inputs are rows of four 16-bit elements. `out_r0` holds element 0 of `in_a0`, `in_a1`, `in_a2` and `in_a3`, in that order from bits [63:48] downward. `out_r1` holds element 1 of each input in the same order.
- R5: Code 2 (transpose low). This works as R4, but `out_r0` holds element 2 of each input and `out_r1` holds element 3.
- R6: Code 3 (average). Each unsigned byte of `out_r0` equals (a0+a1+a2+a3+2)>>2 over the matching bytes of the four inputs, without overflow, so four bytes of 255 give 255. `out_r1` is zero.
- R7: Code 4 (double multiply). `out_r0` is the signed 64-bit product of bits [31:0] of `in_a0` and `in_a1`. `out_r1` is the signed 64-bit product of bits [63:32] of the same two inputs.
- R8: Code 5 (rotate). Per 16-bit signed lane, with X=`in_a0`, Y=`in_a1`, C=`in_a2` and S=`in_a3`: `out_r0` = (C·X+S·Y+8192)>>>14 and `out_r1` = (C·Y−S·X+8192)>>>14.
- R9: A rotate result above 32767 is clamped to 32767, and one below −32768 is clamped to −32768.
- R10: Codes 6 and 7 return zero on both results and still raise `out_vld` as in R1.
- R11: Operations of different codes issued on consecutive cycles each produce their own correct result, one per cycle and in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation issue strobe |
| in_op | input | 3 | Operation code |
| in_a0 | input | 64 | Argument vector 0 |
| in_a1 | input | 64 | Argument vector 1 |
| in_a2 | input | 64 | Argument vector 2 |
| in_a3 | input | 64 | Argument vector 3 |
| out_vld | output | 1 | Result valid |
| out_r0 | output | 64 | First result vector |
| out_r1 | output | 64 | Second result vector |

## Verification
A stage register that holds a stale opcode or a stale valid bit would show up three edges after issue. It would appear as a valid pulse in the wrong cycle or as a result built by the kernel of a neighbouring operation, which back-to-back mixed traffic exposes at once. A wrong lane index or a wrong element order would show up in the first result of a select or transpose whose elements are all distinct. A rounding or clamping fault would show up only on the directed averages and rotations that sit at the edges of the ranges, on the same third edge.

// File: rtl/simd_superop_unit.sv
module simd_superop_unit #(
  parameter int FRAC = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [2:0]  in_op,
  input  logic [63:0] in_a0,
  input  logic [63:0] in_a1,
  input  logic [63:0] in_a2,
  input  logic [63:0] in_a3,
  output logic        out_vld,
  output logic [63:0] out_r0,
  output logic [63:0] out_r1
);
  localparam int HL   = 4;
  localparam int BL   = 8;
  localparam int PW   = 34;
  localparam int SW   = PW - FRAC;
  localparam logic [2:0] OP_SEL = 3'd0, OP_TRH = 3'd1, OP_TRL = 3'd2,
                         OP_AVG = 3'd3, OP_MUL = 3'd4, OP_ROT = 3'd5;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] SMAX = SW'(32767);
  localparam logic signed [SW-1:0] SMIN = -SW'(32768);

  // stage 1: argument capture
  logic        s1_vld;
  logic [2:0]  s1_op;
  logic [63:0] s1_a0, s1_a1, s1_a2, s1_a3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_op  <= '0;
      s1_a0  <= '0;
      s1_a1  <= '0;
      s1_a2  <= '0;
      s1_a3  <= '0;
    end else begin
      s1_vld <= in_vld;
      s1_op  <= in_op;
      s1_a0  <= in_a0;
      s1_a1  <= in_a1;
      s1_a2  <= in_a2;
      s1_a3  <= in_a3;
    end
  end

  // stage 2 combinational kernels
  logic [63:0] sel_r, avg_r;
  logic [63:0] trh0, trh1, trl0, trl1;
  logic signed [63:0] mul_lo, mul_hi;
  logic signed [PW-1:0] rx [HL];
  logic signed [PW-1:0] ry [HL];

  assign trh0 = {s1_a0[63:48], s1_a1[63:48], s1_a2[63:48], s1_a3[63:48]};
  assign trh1 = {s1_a0[47:32], s1_a1[47:32], s1_a2[47:32], s1_a3[47:32]};
  assign trl0 = {s1_a0[31:16], s1_a1[31:16], s1_a2[31:16], s1_a3[31:16]};
  assign trl1 = {s1_a0[15:0],  s1_a1[15:0],  s1_a2[15:0],  s1_a3[15:0]};

  assign mul_lo = 64'($signed(s1_a0[31:0]))  * 64'($signed(s1_a1[31:0]));
  assign mul_hi = 64'($signed(s1_a0[63:32])) * 64'($signed(s1_a1[63:32]));

  for (genvar i = 0; i < HL; i++) begin : g_half
    logic signed [15:0] x, y, c, s;
    logic signed [31:0] cx, sy, cy, sx;
    assign x  = s1_a0[16*i +: 16];
    assign y  = s1_a1[16*i +: 16];
    assign c  = s1_a2[16*i +: 16];
    assign s  = s1_a3[16*i +: 16];
    assign cx = 32'(c) * 32'(x);
    assign sy = 32'(s) * 32'(y);
    assign cy = 32'(c) * 32'(y);
    assign sx = 32'(s) * 32'(x);
    assign rx[i] = PW'(cx) + PW'(sy);
    assign ry[i] = PW'(cy) - PW'(sx);
    assign sel_r[16*i +: 16] = (s1_a2[16*i +: 16] != 16'd0) ? s1_a1[16*i +: 16]
                                                            : s1_a0[16*i +: 16];
  end

  for (genvar i = 0; i < BL; i++) begin : g_byte
    logic [9:0] sum;
    assign sum = 10'(s1_a0[8*i +: 8]) + 10'(s1_a1[8*i +: 8])
               + 10'(s1_a2[8*i +: 8]) + 10'(s1_a3[8*i +: 8]) + 10'd2;
    assign avg_r[8*i +: 8] = sum[9:2];
  end

  // stage 2 registers
  logic        s2_vld;
  logic [2:0]  s2_op;
  logic [63:0] s2_r0, s2_r1;
  logic signed [PW-1:0] s2_rx [HL];
  logic signed [PW-1:0] s2_ry [HL];
  logic [63:0] k_r0, k_r1;

  always_comb begin
    k_r0 = '0;
    k_r1 = '0;
    case (s1_op)
      OP_SEL: k_r0 = sel_r;
      OP_TRH: begin k_r0 = trh0; k_r1 = trh1; end
      OP_TRL: begin k_r0 = trl0; k_r1 = trl1; end
      OP_AVG: k_r0 = avg_r;
      OP_MUL: begin k_r0 = mul_lo; k_r1 = mul_hi; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_op  <= '0;
      s2_r0  <= '0;
      s2_r1  <= '0;
      for (int i = 0; i < HL; i++) begin
        s2_rx[i] <= '0;
        s2_ry[i] <= '0;
      end
    end else begin
      s2_vld <= s1_vld;
      s2_op  <= s1_op;
      s2_r0  <= k_r0;
      s2_r1  <= k_r1;
      for (int i = 0; i < HL; i++) begin
        s2_rx[i] <= rx[i];
        s2_ry[i] <= ry[i];
      end
    end
  end

  // stage 3: rotate rounding and clamping
  logic [63:0] rot0, rot1;

  for (genvar i = 0; i < HL; i++) begin : g_sat
    logic signed [SW-1:0] qx, qy;
    assign qx = SW'((s2_rx[i] + RND) >>> FRAC);
    assign qy = SW'((s2_ry[i] + RND) >>> FRAC);
    assign rot0[16*i +: 16] = (qx > SMAX) ? 16'h7fff : (qx < SMIN) ? 16'h8000 : qx[15:0];
    assign rot1[16*i +: 16] = (qy > SMAX) ? 16'h7fff : (qy < SMIN) ? 16'h8000 : qy[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_r0  <= '0;
      out_r1  <= '0;
    end else begin
      out_vld <= s2_vld;
      out_r0  <= (s2_op == OP_ROT) ? rot0 : s2_r0;
      out_r1  <= (s2_op == OP_ROT) ? rot1 : s2_r1;
    end
  end
endmodule

// File: rtl/simd_superop_unit_chk.sv
module simd_superop_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [2:0]  in_op,
  input logic [15:0] a0_hi,
  input logic [15:0] a3_hi,
  input logic [15:0] a0_lo,
  input logic [15:0] a1_lo,
  input logic [15:0] a2_lo,
  input logic        out_vld,
  input logic [63:0] out_r0,
  input logic [63:0] out_r1
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_vld && out_r0 == 64'd0 && out_r1 == 64'd0));

  a_r3_select_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_vld && $past(in_op, 3) == 3'd0) |->
      (out_r1 == 64'd0 &&
       out_r0[15:0] == (($past(a2_lo, 3) != 16'd0) ? $past(a1_lo, 3) : $past(a0_lo, 3))));

  a_r4_transpose_corner: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_vld && $past(in_op, 3) == 3'd1) |->
      (out_r0[63:48] == $past(a0_hi, 3) && out_r0[15:0] == $past(a3_hi, 3)));

  a_r10_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_vld && $past(in_op, 3) >= 3'd6) |->
      (out_r0 == 64'd0 && out_r1 == 64'd0));
endmodule

bind simd_superop_unit simd_superop_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
  .a0_hi(in_a0[63:48]), .a3_hi(in_a3[63:48]),
  .a0_lo(in_a0[15:0]), .a1_lo(in_a1[15:0]), .a2_lo(in_a2[15:0]),
  .out_vld(out_vld), .out_r0(out_r0), .out_r1(out_r1)
);

// File: tb/simd_superop_unit_bench.sv
module simd_superop_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a0 = '0, in_a1 = '0, in_a2 = '0, in_a3 = '0;
  logic        out_vld;
  logic [63:0] out_r0, out_r1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        q_vld [3];
  logic [63:0] q_r0 [3];
  logic [63:0] q_r1 [3];
  string       q_tag [3];

  always #2 clk = ~clk;

  simd_superop_unit u_simd_superop_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_a0(in_a0), .in_a1(in_a1), .in_a2(in_a2), .in_a3(in_a3),
    .out_vld(out_vld), .out_r0(out_r0), .out_r1(out_r1)
  );

  function automatic logic [15:0] rot_lane(shortint c, shortint p, shortint s, shortint q, bit minus);
    longint t;
    t = minus ? (longint'(c) * p - longint'(s) * q) : (longint'(c) * p + longint'(s) * q);
    t = (t + 8192) >>> 14;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return 16'(t);
  endfunction

  task automatic model(input logic [2:0] op, input logic [63:0] a0, a1, a2, a3,
                       output logic [63:0] r0, output logic [63:0] r1);
    r0 = '0;
    r1 = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++)
              r0[16*i +: 16] = (a2[16*i +: 16] != 0) ? a1[16*i +: 16] : a0[16*i +: 16];
      3'd1: begin
        r0 = {a0[63:48], a1[63:48], a2[63:48], a3[63:48]};
        r1 = {a0[47:32], a1[47:32], a2[47:32], a3[47:32]};
      end
      3'd2: begin
        r0 = {a0[31:16], a1[31:16], a2[31:16], a3[31:16]};
        r1 = {a0[15:0], a1[15:0], a2[15:0], a3[15:0]};
      end
      3'd3: for (int i = 0; i < 8; i++) begin
              int s;
              s = int'(a0[8*i +: 8]) + int'(a1[8*i +: 8]) + int'(a2[8*i +: 8]) + int'(a3[8*i +: 8]);
              r0[8*i +: 8] = 8'((s + 2) / 4);
            end
      3'd4: begin
        r0 = 64'(longint'(int'(a0[31:0])) * longint'(int'(a1[31:0])));
        r1 = 64'(longint'(int'(a0[63:32])) * longint'(int'(a1[63:32])));
      end
      3'd5: for (int i = 0; i < 4; i++) begin
              shortint x, y, c, s;
              x = a0[16*i +: 16]; y = a1[16*i +: 16];
              c = a2[16*i +: 16]; s = a3[16*i +: 16];
              r0[16*i +: 16] = rot_lane(c, x, s, y, 1'b0);
              r1[16*i +: 16] = rot_lane(c, y, s, x, 1'b1);
            end
      default: ;
    endcase
  endtask

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] op,
                      input logic [63:0] a0, a1, a2, a3, input string tag);
    logic [63:0] e0, e1;
    @(negedge clk);
    checks++;
    if (out_vld !== q_vld[2]) begin
      errors++;
      $display("FAIL R1 out_vld got %b exp %b", out_vld, q_vld[2]);
    end
    if (q_vld[2]) begin
      checks++;
      if (out_r0 !== q_r0[2] || out_r1 !== q_r1[2]) begin
        errors++;
        $display("FAIL %s r0/r1 got %h %h exp %h %h", q_tag[2], out_r0, out_r1, q_r0[2], q_r1[2]);
      end
    end
    model(op, a0, a1, a2, a3, e0, e1);
    for (int k = 2; k > 0; k--) begin
      q_vld[k] = q_vld[k-1]; q_r0[k] = q_r0[k-1]; q_r1[k] = q_r1[k-1]; q_tag[k] = q_tag[k-1];
    end
    q_vld[0] = v; q_r0[0] = e0; q_r1[0] = e1;
    q_tag[0] = (tag == "") ? op_tag(op) : tag;
    in_vld = v; in_op = op; in_a0 = a0; in_a1 = a1; in_a2 = a2; in_a3 = a3;
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    for (int k = 0; k < 3; k++) begin
      q_vld[k] = 1'b0; q_r0[k] = '0; q_r1[k] = '0; q_tag[k] = "R1";
    end
    void'($urandom(32'd1977));
    in_vld = 1'b1;
    in_op = 3'd4;
    in_a0 = '1;
    in_a1 = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_r0 !== 64'd0 || out_r1 !== 64'd0) begin
      errors++;
      $display("FAIL R2 reset outputs got %b %h %h exp 0 0 0", out_vld, out_r0, out_r1);
    end
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 3'd0, 64'h1111_2222_3333_4444, 64'haaaa_bbbb_cccc_dddd, 64'h0000_0001_8000_0000, '0, "R3");
    step(1, 3'd1, 64'h000a_000b_000c_000d, 64'h000e_000f_0010_0011,
         64'h0012_0013_0014_0015, 64'h0016_0017_0018_0019, "R4");
    step(1, 3'd2, 64'h000a_000b_000c_000d, 64'h000e_000f_0010_0011,
         64'h0012_0013_0014_0015, 64'h0016_0017_0018_0019, "R5");
    step(1, 3'd3, '1, '1, '1, '1, "R6");
    step(1, 3'd3, 64'h0001_0203_0001_0000, 64'h0000_0000_0100_0000,
         64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, "R6");
    step(1, 3'd4, 64'h8000_0000_8000_0000, 64'h8000_0000_7fff_ffff, '0, '0, "R7");
    step(1, 3'd5, 64'h2000_e000_0001_4000, 64'h1000_1000_0002_0000,
         64'h4000_4000_2d41_4000, 64'h0000_0000_2d41_0000, "R8");
    step(1, 3'd5, {4{16'h7fff}}, {4{16'h7fff}}, {4{16'h7fff}}, {4{16'h7fff}}, "R9");
    step(1, 3'd5, {4{16'h8000}}, {4{16'h8000}}, {4{16'h7fff}}, {4{16'h7fff}}, "R9");
    step(0, 3'd1, '1, '1, '1, '1, "R1");
    step(1, 3'd6, '1, '1, '1, '1, "R10");
    step(1, 3'd7, r64(), r64(), r64(), r64(), "R10");
    for (int n = 0; n < 6; n++)
      step(1, 3'(n), r64(), r64(), r64(), r64(), "R11");
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 3) != 0), op, r64(), r64(),
           ($urandom_range(0, 1) != 0) ? (r64() & 64'hffff_0000_ffff_0000) : r64(), r64(), "");
    end
    repeat (4) step(0, 3'd0, '0, '0, '0, '0, "R1");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired got hung exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule